// File: doc/BRIEF.md
# Partitioned Packed Integer ALU

This block is a 64-bit integer ALU for packed data. It has its own file of eight 64-bit registers. Each instruction names two source registers and one destination register, and it picks how a 64-bit word is split into lanes: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes, or one 64-bit lane. The chosen operation then runs on every lane in the same cycle.

A single byte-sliced adder does all of the arithmetic. The carry chain is cut at each lane boundary, so one datapath covers every lane size. Add and subtract normally wrap within each lane. When the saturate bit is set, they clamp instead, using unsigned limits.

A separate load port writes a register directly, so software can seed operands. If a load and an issue happen in the same cycle, the value being loaded is forwarded to the instruction's operands. Each result is registered and appears one cycle after issue. In that same edge it is written back to the destination register.

Top module: `pk_alu`

## Requirements
- R1: After reset all eight registers read as zero, and `res_valid` is low.
- R2: When `wr_en` is high, `wr_data` is written into register `wr_idx` on the clock edge.
- R3: Add (`iss_op`=000) and subtract (`iss_op`=001) work per lane and wrap modulo the lane size. The lane size field `iss_width` is encoded as 00=8-bit, 01=16-bit, 10=32-bit, 11=64-bit. No carry or borrow crosses a lane boundary.
- R4: AND (`iss_op`=010), OR (011) and XOR (100) operate bitwise on all 64 bits. Their result does not depend on `iss_width` or `iss_sat`.
- R5: When `iss_sat` is 1, an add lane that overflows gives all ones, and a subtract lane that borrows gives zero.
- R6: An issue at edge N drives `res_data` with `res_valid` high after edge N, and writes the result to register `iss_dst` at that edge. After a cycle without an issue, `res_valid` is low and `res_data` keeps its value.
- R7: If the load port writes a register in the same cycle that an issue reads it, the issue uses `wr_data`.
- R8: If a load and an issue target the same register at the same edge, the loaded value is the one that stays in that register.
- R9: Operation codes 101, 110 and 111 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load-port write enable |
| wr_idx | input | 3 | Load-port register index |
| wr_data | input | 64 | Load-port data |
| iss_valid | input | 1 | Instruction issue |
| iss_op | input | 3 | Operation code |
| iss_width | input | 2 | Lane size |
| iss_sat | input | 1 | Unsigned saturation enable |
| iss_src_a | input | 3 | First source register |
| iss_src_b | input | 3 | Second source register |
| iss_dst | input | 3 | Destination register |
| res_valid | output | 1 | Result valid, one cycle after issue |
| res_data | output | 64 | Result value |

## Verification
The assertions check several things on every cycle. They check the one-cycle result timing. They check that the two lowest 8-bit lanes of an unsaturated packed add stay isolated from each other. They check the saturation bounds for 64-bit add and subtract, the XOR result, the zero result of unused codes, and forwarding from the load port.

Some behaviours appear only in the bench's scenarios. These are the register writeback seen by later instructions, the priority of a load over a result written to the same register, carry isolation at wider lane sizes, and per-lane clamping.

// File: rtl/pk_alu.sv
module pk_alu #(
  parameter int NREGS = 8,
  parameter int IW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [63:0]   wr_data,
  input  logic          iss_valid,
  input  logic [2:0]    iss_op,
  input  logic [1:0]    iss_width,
  input  logic          iss_sat,
  input  logic [IW-1:0] iss_src_a,
  input  logic [IW-1:0] iss_src_b,
  input  logic [IW-1:0] iss_dst,
  output logic          res_valid,
  output logic [63:0]   res_data
);
  localparam int NB = 8;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2,
                         OP_OR  = 3'd3, OP_XOR = 3'd4;

  logic [63:0] rf [NREGS];
  logic [63:0] opa, opb, sum, arith, alu;
  logic [NB-1:0] co;
  logic is_sub, carry;
  logic [8:0] s9;
  int lmask;

  assign opa = (wr_en && wr_idx == iss_src_a) ? wr_data : rf[iss_src_a];
  assign opb = (wr_en && wr_idx == iss_src_b) ? wr_data : rf[iss_src_b];
  assign is_sub = (iss_op == OP_SUB);
  assign lmask = (1 << iss_width) - 1;

  always_comb begin
    carry = is_sub;
    sum = '0;
    co = '0;
    s9 = '0;
    for (int i = 0; i < NB; i++) begin
      if ((i & lmask) == 0) carry = is_sub;
      s9 = {1'b0, opa[i*8 +: 8]} + {1'b0, is_sub ? ~opb[i*8 +: 8] : opb[i*8 +: 8]} + {8'd0, carry};
      sum[i*8 +: 8] = s9[7:0];
      co[i] = s9[8];
      carry = s9[8];
    end
  end

  always_comb begin
    arith = sum;
    for (int i = 0; i < NB; i++) begin
      if (iss_sat && !is_sub && co[i | lmask])  arith[i*8 +: 8] = 8'hFF;
      if (iss_sat &&  is_sub && !co[i | lmask]) arith[i*8 +: 8] = 8'h00;
    end
  end

  always_comb begin
    case (iss_op)
      OP_ADD, OP_SUB: alu = arith;
      OP_AND:         alu = opa & opb;
      OP_OR:          alu = opa | opb;
      OP_XOR:         alu = opa ^ opb;
      default:        alu = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) rf[r] <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= iss_valid;
      if (iss_valid) begin
        res_data    <= alu;
        rf[iss_dst] <= alu;
      end
      if (wr_en) rf[wr_idx] <= wr_data;
    end
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(iss_valid));
  p_lane0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_op == OP_ADD && !iss_sat && iss_width == 2'b00
      |=> res_data[7:0] == $past(opa[7:0] + opb[7:0]));
  p_lane1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_op == OP_ADD && !iss_sat && iss_width == 2'b00
      |=> res_data[15:8] == $past(opa[15:8] + opb[15:8]));
  p_sat_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_op == OP_ADD && iss_sat && iss_width == 2'b11
      |=> res_data >= $past(opa));
  p_sat_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_op == OP_SUB && iss_sat && iss_width == 2'b11
      |=> res_data <= $past(opa));
  p_xor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_op == OP_XOR |=> res_data == $past(opa ^ opb));
  p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_op > OP_XOR |=> res_data == 64'd0);
  p_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && wr_en && iss_op == OP_AND && wr_idx == iss_src_a && wr_idx == iss_src_b
      |=> res_data == $past(wr_data));
endmodule

// File: tb/pk_alu_tb.sv
module pk_alu_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, iss_valid = 0, iss_sat = 0;
  logic [2:0] wr_idx = 0, iss_op = 0, iss_src_a = 0, iss_src_b = 0, iss_dst = 0;
  logic [1:0] iss_width = 0;
  logic [63:0] wr_data = 0;
  logic res_valid;
  logic [63:0] res_data;
  logic [63:0] model_rf [8];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pk_alu u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_width(iss_width), .iss_sat(iss_sat),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
    .res_valid(res_valid), .res_data(res_data));

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [2:0] op,
                                        logic [1:0] w, logic s);
    int lb = 8 << w;
    logic [63:0] mask = (w == 2'b11) ? {64{1'b1}} : ((64'd1 << lb) - 1);
    logic [63:0] r = 0;
    logic [64:0] t;
    logic [63:0] x, y;
    case (op)
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd0, 3'd1: ;
      default: return 64'd0;
    endcase
    for (int l = 0; l < (8 >> w); l++) begin
      x = (a >> (l * lb)) & mask;
      y = (b >> (l * lb)) & mask;
      if (op == 3'd0) begin
        t = {1'b0, x} + {1'b0, y};
        if (s && t > {1'b0, mask}) t = {1'b0, mask};
      end else begin
        if (s && y > x) t = 0;
        else t = {1'b0, x - y};
      end
      r = r | ((t[63:0] & mask) << (l * lb));
    end
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(bit dw, logic [2:0] wi, logic [63:0] wd, bit di, logic [2:0] op,
                      logic [1:0] w, bit s, logic [2:0] a, logic [2:0] b, logic [2:0] d,
                      string req);
    logic [63:0] va, vb, exp;
    wr_en = dw; wr_idx = wi; wr_data = wd;
    iss_valid = di; iss_op = op; iss_width = w; iss_sat = s;
    iss_src_a = a; iss_src_b = b; iss_dst = d;
    va = (dw && wi == a) ? wd : model_rf[a];
    vb = (dw && wi == b) ? wd : model_rf[b];
    exp = model(va, vb, op, w, s);
    @(posedge clk); #2;
    if (di) begin
      chk(req, {63'd0, res_valid}, 64'd1);
      chk(req, res_data, exp);
      model_rf[d] = exp;
    end
    if (dw) model_rf[wi] = wd;
    @(negedge clk);
    wr_en = 0; iss_valid = 0;
  endtask

  task automatic load(logic [2:0] i, logic [63:0] v);
    step(1, i, v, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model_rf[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", {63'd0, res_valid}, 64'd0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 3'd3, 0, 0, i[2:0], i[2:0], 7, "R1");

    load(1, 64'hFFFF_FFFF_FFFF_FFFF);
    load(2, 64'h0000_0000_0000_0001);
    load(3, 64'h0101_0101_0101_0101);
    step(0, 0, 0, 1, 3'd3, 0, 0, 1, 1, 6, "R2");
    // R3 carry isolation at every lane size
    for (int w = 0; w < 4; w++) step(0, 0, 0, 1, 3'd0, w[1:0], 0, 1, 2, 4, "R3");
    for (int w = 0; w < 4; w++) step(0, 0, 0, 1, 3'd0, w[1:0], 0, 1, 3, 4, "R3");
    for (int w = 0; w < 4; w++) step(0, 0, 0, 1, 3'd1, w[1:0], 0, 2, 3, 4, "R3");
    // R5 saturation
    for (int w = 0; w < 4; w++) step(0, 0, 0, 1, 3'd0, w[1:0], 1, 1, 3, 4, "R5");
    for (int w = 0; w < 4; w++) step(0, 0, 0, 1, 3'd1, w[1:0], 1, 2, 3, 4, "R5");
    // R4 bitwise independent of width and sat
    for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 3'd2 + k[1:0] % 3, k[1:0], k[2], 1, 3, 5, "R4");
    // R9 unused codes
    for (int o = 5; o < 8; o++) step(0, 0, 0, 1, o[2:0], 0, 0, 1, 1, 5, "R9");
    // R6 writeback then idle hold
    step(0, 0, 0, 1, 3'd0, 2'b00, 0, 3, 3, 0, "R6");
    begin
      logic [63:0] held;
      held = res_data;
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
      chk("R6", {63'd0, res_valid}, 64'd0);
      chk("R6", res_data, held);
    end
    step(0, 0, 0, 1, 3'd3, 0, 0, 0, 0, 7, "R6");
    // R7 forwarding
    step(1, 5, 64'h1234_5678_9ABC_DEF0, 1, 3'd0, 2'b01, 0, 5, 3, 6, "R7");
    // R8 load wins over result
    step(1, 4, 64'hCAFE_F00D_0000_0001, 1, 3'd0, 2'b11, 0, 1, 1, 4, "R8");
    step(0, 0, 0, 1, 3'd3, 0, 0, 4, 4, 7, "R8");

    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if (op > 4 && ($urandom & 3) != 0) op = 3'($urandom_range(0, 1));
      step($urandom & 1, 3'($urandom), {$urandom, $urandom}, 1, op, 2'($urandom), $urandom & 1,
           3'($urandom), 3'($urandom), 3'($urandom), op < 2 ? "R3" : (op < 5 ? "R4" : "R9"));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule